// File: doc/BRIEF.md
# Hash Result Byte Streamer

This block sits behind a hash core and delivers the finished digest to a microcontroller over a narrow parallel bus. When the core signals completion with a one-cycle start pulse, the streamer captures the 256-bit chaining state, the requested digest length and the output pace. It then plays the digest out one byte per step on an 8-bit bus, qualified by a valid flag.

The first step of every sequence is a start marker. During the marker, valid is high and the bus carries zero, so a capture engine on the host side can lock onto the stream before any data arrives. The result bytes follow without gaps, lowest-index byte first. Once the last byte has been shown, a one-cycle done pulse tells the input side that a new job may be configured.

A 2-bit pace input selects the step length. Fast pace uses one clock per step, and slow pace uses two clocks per step for output pads that cannot toggle at the full clock rate.

Top module: `hash_stream_out`

## Requirements
- R1: A start pulse seen while idle is accepted at that clock edge. Valid goes high in the cycle that follows, and it never rises without a start pulse at the preceding edge.
- R2: The first step after acceptance is the marker step: valid is 1 and the data bus is 0x00.
- R3: After the marker, exactly n data steps follow, where n is the captured length. Valid then drops.
- R4: Data step k (k = 0 first) presents bits [8k+7:8k] of the captured 256-bit state, so byte 0 is the least significant byte.
- R5: Any pace value other than 3 (0, 1 or 2) gives one clock cycle per step.
- R6: Pace value 3 gives two clock cycles per step. The bus and valid hold steady within a step.
- R7: State, length and pace are captured at acceptance. Changing those inputs later has no effect on the running sequence.
- R8: A start pulse that arrives while a sequence is running is ignored. The running sequence continues unchanged and no new sequence follows it.
- R9: Whenever the block is idle, valid is 0 and the data bus is 0x00, regardless of the state input.
- R10: done is high for exactly one cycle, in the cycle right after the last data step, and valid is 0 in that cycle.
- R11: A length of 0 is treated as 1. A length above 32 is treated as 32.
- R12: Valid stays high without a break from the marker step through the last data step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: the digest is ready |
| state_i | input | 256 | Final chaining state, byte 0 in bits [7:0] |
| nn_i | input | 6 | Requested digest length in bytes |
| mode_i | input | 2 | Pace select: 3 = slow, any other value = fast |
| hash_valid_o | output | 1 | High during the marker and the data steps |
| hash_o | output | 8 | Result byte; 0x00 during the marker and when idle |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench instantiates the block with its default parameters: a 32-byte state and a step divider of 2 for slow pace. With these values the 6-bit length field covers every length from 0 to 63. The bench therefore reaches both clamp boundaries and the full 32-byte digest under both paces. It also checks every pace code, and it drives busy-time start pulses together with input churn against a cycle-exact expected stream.

// File: rtl/hso_pkg.sv
package hso_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MARK = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_SLOW = 2'd3;
endpackage

// File: rtl/hso_pacer.sv
module hso_pacer #(
  parameter int SLOW_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_i,
  output logic step_end_o
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_end_o = run_i && (cnt_q == (slow_i ? SLOW_LAST : '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (step_end_o)  cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hso_byte_sel.sv
module hso_byte_sel #(
  parameter int STATE_BYTES = 32,
  parameter int IDX_W       = 5
) (
  input  logic [STATE_BYTES*8-1:0] state_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [7:0]               byte_o
);
  logic [7:0] lane [STATE_BYTES];

  for (genvar g = 0; g < STATE_BYTES; g++) begin : g_lane
    assign lane[g] = state_i[g*8 +: 8];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/hso_seq.sv
module hso_seq
  import hso_pkg::*;
#(
  parameter int STATE_BYTES = 32,
  parameter int NN_W        = 6,
  parameter int IDX_W       = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NN_W-1:0] nn_i,
  input  logic [1:0]      mode_i,
  input  logic            step_end_i,
  output phase_e          phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic            slow_o,
  output logic            done_o,
  output logic            load_o
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             slow_q, done_q;
  logic [NN_W-1:0]  nn_eff;

  always_comb begin
    if (nn_i == '0)                        nn_eff = NN_W'(1);
    else if (nn_i > NN_W'(STATE_BYTES))    nn_eff = NN_W'(STATE_BYTES);
    else                                   nn_eff = nn_i;
  end

  assign load_o  = start_i && (phase_q == PH_IDLE);
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign slow_o  = slow_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      slow_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_MARK;
          idx_q   <= '0;
          last_q  <= IDX_W'(nn_eff - NN_W'(1));
          slow_q  <= (mode_i == MODE_SLOW);
        end
        PH_MARK: if (step_end_i) phase_q <= PH_DATA;
        PH_DATA: if (step_end_i) begin
          if (idx_q == last_q) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hash_stream_out.sv
module hash_stream_out
  import hso_pkg::*;
#(
  parameter int STATE_BYTES = 32,
  parameter int SLOW_DIV    = 2,
  parameter int NN_W        = $clog2(STATE_BYTES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [STATE_BYTES*8-1:0] state_i,
  input  logic [NN_W-1:0]          nn_i,
  input  logic [1:0]               mode_i,
  output logic                     hash_valid_o,
  output logic [7:0]               hash_o,
  output logic                     done_o
);
  localparam int IDX_W = (STATE_BYTES > 1) ? $clog2(STATE_BYTES) : 1;

  phase_e                   phase;
  logic [IDX_W-1:0]         idx;
  logic                     slow_q, step_end, load;
  logic [STATE_BYTES*8-1:0] state_q;
  logic [7:0]               sel_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= '0;
    else if (load) state_q <= state_i;
  end

  hso_seq #(.STATE_BYTES(STATE_BYTES), .NN_W(NN_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .nn_i, .mode_i,
    .step_end_i(step_end), .phase_o(phase), .idx_o(idx),
    .slow_o(slow_q), .done_o, .load_o(load)
  );

  hso_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
    .clk_i, .rst_ni, .run_i(phase != PH_IDLE), .slow_i(slow_q),
    .step_end_o(step_end)
  );

  hso_byte_sel #(.STATE_BYTES(STATE_BYTES), .IDX_W(IDX_W)) u_sel (
    .state_i(state_q), .idx_i(idx), .byte_o(sel_byte)
  );

  assign hash_valid_o = (phase != PH_IDLE);
  assign hash_o       = (phase == PH_DATA) ? sel_byte : 8'h00;
endmodule

// File: rtl/hso_checker.sv
module hso_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       hash_valid_o,
  input logic [7:0] hash_o,
  input logic       done_o,
  input logic       slow_i,
  input logic       step_end_i
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hash_valid_o |-> hash_o == 8'h00); // R9
  AST_START_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hash_valid_o) |-> $past(start_i)); // R1
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hash_valid_o && $past(hash_valid_o)); // R10
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hash_valid_o) |-> done_o); // R12
  AST_SLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i && hash_valid_o && !step_end_i |=> hash_valid_o && $stable(hash_o)); // R6
endmodule

bind hash_stream_out hso_checker u_chk (
  .clk_i, .rst_ni, .start_i, .hash_valid_o, .hash_o, .done_o,
  .slow_i(slow_q), .step_end_i(step_end)
);

// File: tb/sim_hash_stream_out.sv
`timescale 1ns/1ps
module sim_hash_stream_out;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [255:0] state_i = '0;
  logic [5:0]   nn_i = '0;
  logic [1:0]   mode_i = '0;
  logic         hash_valid_o, done_o;
  logic [7:0]   hash_o;

  int n_chk = 0;
  int n_bad = 0;

  hash_stream_out u0 (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic logic [255:0] rnd_state();
    logic [255:0] s;
    for (int i = 0; i < 8; i++) s[i*32 +: 32] = $urandom;
    return s;
  endfunction

  function automatic int eff_len(input logic [5:0] n);
    if (n == 0) return 1;
    if (n > 32) return 32;
    return int'(n);
  endfunction

  // {valid, done, byte} at cycle t after acceptance
  function automatic logic [9:0] exp_at(input logic [255:0] s, input int n,
                                        input int len, input int t);
    int steps = (1 + n) * len;
    int st;
    if (t < steps) begin
      st = t / len;
      if (st == 0) return {2'b10, 8'h00};
      return {2'b10, s[(st-1)*8 +: 8]};
    end
    if (t == steps) return {2'b01, 8'h00};
    return 10'h000;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got {v,d,b}=%03h expected %03h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input logic [255:0] s, input logic [5:0] n,
                         input logic [1:0] m, input bit churn);
    int nl = eff_len(n);
    int len = (m == 2'd3) ? 2 : 1;
    int last = (1 + nl) * len + 1;
    string req;
    @(negedge clk_i);
    start_i = 1'b1; state_i = s; nn_i = n; mode_i = m;
    @(negedge clk_i);
    for (int t = 0; t <= last; t++) begin
      if (t > 0) @(negedge clk_i);
      if (t == 0) req = "R1 R2";
      else if (t == last - 1) req = "R3 R10";
      else if (t == last) req = "R10 R8";
      else req = (len == 2) ? "R4 R6 R12 R11" : "R4 R5 R12 R11";
      if (churn) req = {req, " R7"};
      check(req, {hash_valid_o, done_o, hash_o}, exp_at(s, nl, len, t));
      start_i = (churn && t == 0) ? 1'b1 : 1'b0; // busy start -> R8
      if (churn) begin
        state_i = rnd_state(); nn_i = 6'($urandom); mode_i = 2'($urandom);
      end
    end
    start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk_i);
    check("R9 reset", {hash_valid_o, done_o, hash_o}, 10'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    state_i = rnd_state(); nn_i = 6'd32; mode_i = 2'd3;
    @(negedge clk_i);
    check("R9 idle", {hash_valid_o, done_o, hash_o}, 10'h000);

    run_seq(rnd_state(), 6'd1,  2'd0, 1'b0);
    run_seq(rnd_state(), 6'd32, 2'd3, 1'b0);
    run_seq(rnd_state(), 6'd0,  2'd3, 1'b0); // R11 low clamp
    run_seq(rnd_state(), 6'd45, 2'd0, 1'b0); // R11 high clamp
    run_seq(rnd_state(), 6'd63, 2'd3, 1'b0);
    run_seq(rnd_state(), 6'd7,  2'd1, 1'b0); // R5
    run_seq(rnd_state(), 6'd9,  2'd2, 1'b0); // R5
    run_seq(rnd_state(), 6'd16, 2'd0, 1'b1); // R7 R8
    run_seq(rnd_state(), 6'd20, 2'd3, 1'b1); // R7 R8
    for (int i = 0; i < 40; i++)
      run_seq(rnd_state(), 6'($urandom), 2'($urandom), 1'($urandom));

    @(negedge clk_i);
    check("R9 final idle", {hash_valid_o, done_o, hash_o}, 10'h000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule